// File: doc/BRIEF.md
# Host Register Port for a Character Display Controller

This block is the host-facing side of a character display controller. An external processor drives an enable strobe, a register-select line, a read/write line and a data bus. The block brings the three control lines and the data lines into the system clock domain. A write is captured on the falling edge of the enable strobe and routed to an 8-bit command register or an 8-bit data register. Each completed byte raises a one-cycle pulse to the controller core.

Reads work in two ways. With register-select low, the host sees a status word: the busy flag in the top bit and the live address counter below it. The command register itself is never readable. With register-select high, the host sees the data byte that the core has already fetched from memory at the current address. A pulse then tells the core that the byte was consumed.

A nibble mode moves each byte over the upper four data lines in two strobes, high half first. In that mode the lower four lines are ignored on writes and driven low on reads.

Top module: `lcd_host_port`

## Requirements
- R1: After reset, `instr_o` and `data_o` are 0x00, `host_oe_o` is low, and `instr_wr_o`, `data_wr_o` and `data_rd_o` are low.
- R2: In byte mode, a strobe with select=0 and read/write=0 loads the bus value into `instr_o`. `instr_wr_o` goes high for exactly one cycle, in the third clock cycle after the enable falls.
- R3: In byte mode, a strobe with select=1 and read/write=0 loads the bus value into `data_o` with one `data_wr_o` pulse. `instr_o` is left unchanged.
- R4: While a strobe with select=0 and read/write=1 is active, `host_d_o` is {busy_i, addr_ctr_i}, with busy in bit 7 and the counter in bits 6..0.
- R5: While a strobe with select=1 and read/write=1 is active, `host_d_o` is `rd_byte_i`. When the byte completes, `data_rd_o` pulses once. A status read gives no `data_rd_o` pulse.
- R6: `host_oe_o` rises two clock edges after the enable rises during a read, and is low during writes and after the enable falls.
- R7: In nibble mode (`nib_mode_i`=1), a byte is written as two strobes carrying the high half and then the low half on lines 7..4. Lines 3..0 are ignored. The single write pulse follows the second strobe only.
- R8: In nibble mode, a read presents byte bits 7..4 on lines 7..4 during the first strobe and bits 3..0 during the second. Lines 3..0 are driven 0. `data_rd_o` pulses only after the second strobe.
- R9: A command write captured while `busy_i`=1 is dropped: there is no `instr_wr_o` pulse and `instr_o` keeps its value. Data writes are still accepted while busy.
- R10: The command register cannot be read: a select=0 read returns the status word, never `instr_o`.
- R11: `instr_wr_o` and `data_wr_o` are never high together, and each write pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| host_en_i | input | 1 | Host transfer strobe; data is taken on its fall |
| host_rs_i | input | 1 | Register select: 0 command/status, 1 data |
| host_rw_i | input | 1 | 1 read, 0 write |
| host_d_i | input | 8 | Host data bus in |
| host_d_o | output | 8 | Host data bus out |
| host_oe_o | output | 1 | Output enable for the host data bus |
| nib_mode_i | input | 1 | 1 selects the 4-bit transfer mode |
| busy_i | input | 1 | Core busy flag |
| addr_ctr_i | input | 7 | Core address counter |
| rd_byte_i | input | 8 | Byte preloaded by the core for a data read |
| instr_o | output | 8 | Command register |
| instr_wr_o | output | 1 | One-cycle pulse: command written |
| data_o | output | 8 | Data register |
| data_wr_o | output | 1 | One-cycle pulse: data written |
| data_rd_o | output | 1 | One-cycle pulse: data byte read |

## Verification
The enable passes through two synchronizer flops, so the output enable and read data become valid after the second rising clock edge following the strobe's rise. The write and read-done pulses appear after the third edge following its fall and clear after the fourth. The bench changes inputs on falling clock edges and counts rising edges from each change before it samples, again on a falling edge. It checks both the cycle in which a pulse is high and the cycle after, which is low. Pulses are also counted by a monitor over the whole run, so an extra or missing pulse shows up in the per-test totals.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int ADDR_W = DATA_W - 1;

  // status word: busy flag on top, address counter beneath
  function automatic logic [DATA_W-1:0] status_word(input logic bf,
                                                     input logic [ADDR_W-1:0] ac);
    return {bf, ac};
  endfunction

  // place one half of a byte on the upper lanes, lower lanes zero
  function automatic logic [DATA_W-1:0] nib_lane(input logic [DATA_W-1:0] b,
                                                  input logic hi_phase);
    logic [HALF_W-1:0] h;
    h = hi_phase ? b[DATA_W-1:HALF_W] : b[HALF_W-1:0];
    return {h, {HALF_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] join_nib(input logic [HALF_W-1:0] hi,
                                                  input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/lhp_sync.sv
module lhp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lhp_edge.sv
module lhp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;

  assign fall_o = prev & ~lvl_i;

  // R11
  fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/lhp_assemble.sv
module lhp_assemble #(
  parameter int DW = lhp_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic [DW-1:0] din_i,
  input  logic          nib_mode_i,
  input  logic          busy_i,
  output logic          hi_phase_o,
  output logic [DW-1:0] instr_o,
  output logic          instr_wr_o,
  output logic [DW-1:0] data_o,
  output logic          data_wr_o,
  output logic          data_rd_o
);
  localparam int HW = DW / 2;

  logic [HW-1:0] hi_nib;
  logic          byte_done;
  logic [DW-1:0] wr_byte;

  assign byte_done = cap_i & (~nib_mode_i | ~hi_phase_o);
  assign wr_byte   = nib_mode_i ? lhp_pkg::join_nib(hi_nib, din_i[DW-1:HW]) : din_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           hi_phase_o <= 1'b1;
    else if (!nib_mode_i) hi_phase_o <= 1'b1;
    else if (cap_i)       hi_phase_o <= ~hi_phase_o;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_nib <= '0;
    else if (cap_i && nib_mode_i && hi_phase_o && !rw_i) hi_nib <= din_i[DW-1:HW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      instr_o    <= '0;
      data_o     <= '0;
      instr_wr_o <= 1'b0;
      data_wr_o  <= 1'b0;
      data_rd_o  <= 1'b0;
    end else begin
      instr_wr_o <= 1'b0;
      data_wr_o  <= 1'b0;
      data_rd_o  <= 1'b0;
      if (byte_done && !rw_i) begin
        if (rs_i) begin
          data_o    <= wr_byte;
          data_wr_o <= 1'b1;
        end else if (!busy_i) begin
          instr_o    <= wr_byte;
          instr_wr_o <= 1'b1;
        end
      end
      if (byte_done && rw_i && rs_i) data_rd_o <= 1'b1;
    end

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_wr_o && data_wr_o));
  // R2
  instr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr_o |=> !instr_wr_o);
  // R3
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_o |=> !data_wr_o);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr_o |-> !$past(busy_i));
  // R7
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_mode_i && $past(nib_mode_i) && (instr_wr_o || data_wr_o)) |-> hi_phase_o);
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_en_i,
  input  logic                        host_rs_i,
  input  logic                        host_rw_i,
  input  logic [lhp_pkg::DATA_W-1:0]  host_d_i,
  output logic [lhp_pkg::DATA_W-1:0]  host_d_o,
  output logic                        host_oe_o,
  input  logic                        nib_mode_i,
  input  logic                        busy_i,
  input  logic [lhp_pkg::ADDR_W-1:0]  addr_ctr_i,
  input  logic [lhp_pkg::DATA_W-1:0]  rd_byte_i,
  output logic [lhp_pkg::DATA_W-1:0]  instr_o,
  output logic                        instr_wr_o,
  output logic [lhp_pkg::DATA_W-1:0]  data_o,
  output logic                        data_wr_o,
  output logic                        data_rd_o
);
  localparam int DW = lhp_pkg::DATA_W;
  localparam int HW = lhp_pkg::HALF_W;
  localparam int SW = DW + 3;

  logic [SW-1:0] raw, synced;
  logic          en_s, rs_s, rw_s, cap;
  logic [DW-1:0] din_s, rd_word;
  logic          hi_phase;

  assign raw = {host_en_i, host_rs_i, host_rw_i, host_d_i};

  lhp_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  assign {en_s, rs_s, rw_s, din_s} = synced;

  lhp_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl_i(en_s), .fall_o(cap));

  lhp_assemble #(.DW(DW)) u_asm (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .rs_i(rs_s), .rw_i(rw_s),
    .din_i(din_s), .nib_mode_i(nib_mode_i), .busy_i(busy_i),
    .hi_phase_o(hi_phase), .instr_o(instr_o), .instr_wr_o(instr_wr_o),
    .data_o(data_o), .data_wr_o(data_wr_o), .data_rd_o(data_rd_o));

  assign rd_word   = rs_s ? rd_byte_i : lhp_pkg::status_word(busy_i, addr_ctr_i);
  assign host_d_o  = nib_mode_i ? lhp_pkg::nib_lane(rd_word, hi_phase) : rd_word;
  assign host_oe_o = en_s & rw_s;

  // R8
  low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_mode_i |-> host_d_o[HW-1:0] == '0);
  // R6
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_wr_o || data_wr_o) |-> !$past(host_oe_o));
endmodule

// File: tb/sim_lcd_host_port.sv
module sim_lcd_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e = 1'b0, rs = 1'b0, rw = 1'b0, nib = 1'b0, busy = 1'b0;
  logic [7:0] din = '0, rdd = '0;
  logic [6:0] ac = '0;
  logic [7:0] dout, instr, data;
  logic oe, iw, dw, dr;
  int checks = 0, errors = 0;
  int n_iw = 0, n_dw = 0, n_dr = 0;

  always #10 clk = ~clk;

  lcd_host_port u0 (
    .clk(clk), .rst_n(rst_n), .host_en_i(e), .host_rs_i(rs), .host_rw_i(rw),
    .host_d_i(din), .host_d_o(dout), .host_oe_o(oe), .nib_mode_i(nib),
    .busy_i(busy), .addr_ctr_i(ac), .rd_byte_i(rdd), .instr_o(instr),
    .instr_wr_o(iw), .data_o(data), .data_wr_o(dw), .data_rd_o(dr));

  always @(negedge clk) if (rst_n) begin
    if (iw) n_iw++;
    if (dw) n_dw++;
    if (dr) n_dr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one strobe; returns bus out and oe as seen while enable is high
  task automatic strobe(input logic rs_v, input logic rw_v, input logic [7:0] v,
                        output logic [7:0] seen, output logic oe_seen);
    @(negedge clk);
    rs = rs_v; rw = rw_v; din = v; e = 1'b1;
    repeat (3) @(negedge clk);
    seen = dout; oe_seen = oe;
    e = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 instr", instr, 8'h00);
    chk("R1 data", data, 8'h00);
    chk("R1 oe", oe, 1'b0);
    chk("R1 pulses", {iw, dw, dr}, 3'b000);
  endtask

  task automatic t_instr_write;
    int b = n_iw;
    @(negedge clk);
    rs = 0; rw = 0; din = 8'h38; e = 1;
    repeat (3) @(negedge clk);
    chk("R6 oe low in write", oe, 1'b0);
    e = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 no pulse yet", iw, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2 pulse due", iw, 1'b1);
    chk("R11 not both", dw, 1'b0);
    @(negedge clk);
    chk("R11 pulse one cycle", iw, 1'b0);
    chk("R2 instr", instr, 8'h38);
    repeat (3) @(negedge clk);
    chk("R2 count", n_iw - b, 1);
  endtask

  task automatic t_data_write;
    logic [7:0] s; logic o;
    int b = n_dw, bi = n_iw;
    strobe(1, 0, 8'hA5, s, o);
    chk("R3 data", data, 8'hA5);
    chk("R3 count", n_dw - b, 1);
    chk("R3 instr kept", instr, 8'h38);
    chk("R3 no instr pulse", n_iw - bi, 0);
  endtask

  task automatic t_status_read;
    logic [7:0] s; logic o;
    int b = n_dr;
    busy = 0; ac = 7'h45;
    strobe(0, 1, 8'h00, s, o);
    chk("R4 status idle", s, 8'h45);
    chk("R10 not instr", s == instr, 1'b0);
    busy = 1; ac = 7'h12;
    strobe(0, 1, 8'h00, s, o);
    chk("R4 status busy", s, 8'h92);
    busy = 0;
    chk("R5 no rd pulse on status", n_dr - b, 0);
  endtask

  task automatic t_data_read;
    logic [7:0] s; logic o;
    int b = n_dr;
    rdd = 8'h5C;
    strobe(1, 1, 8'h00, s, o);
    chk("R5 data read", s, 8'h5C);
    chk("R5 rd pulse", n_dr - b, 1);
  endtask

  task automatic t_oe_timing;
    @(negedge clk);
    rs = 1; rw = 1; e = 1;
    @(negedge clk);
    chk("R6 oe after one edge", oe, 1'b0);
    @(negedge clk);
    chk("R6 oe after two edges", oe, 1'b1);
    e = 0;
    repeat (2) @(negedge clk);
    chk("R6 oe after fall", oe, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy;
    logic [7:0] s; logic o;
    int bi = n_iw, bd = n_dw;
    busy = 1;
    strobe(0, 0, 8'h01, s, o);
    chk("R9 instr kept", instr, 8'h38);
    chk("R9 no pulse", n_iw - bi, 0);
    strobe(1, 0, 8'h77, s, o);
    chk("R9 data accepted", data, 8'h77);
    chk("R9 data pulse", n_dw - bd, 1);
    busy = 0;
  endtask

  task automatic t_nib_write;
    logic [7:0] s; logic o;
    int bi = n_iw, bd = n_dw;
    nib = 1;
    repeat (2) @(negedge clk);
    strobe(0, 0, 8'h3F, s, o);
    chk("R7 no pulse after first half", n_iw - bi, 0);
    strobe(0, 0, 8'hC5, s, o);
    chk("R7 instr", instr, 8'h3C);
    chk("R7 one pulse", n_iw - bi, 1);
    strobe(1, 0, 8'hE0, s, o);
    strobe(1, 0, 8'h7A, s, o);
    chk("R7 data", data, 8'hE7);
    chk("R7 data pulse", n_dw - bd, 1);
  endtask

  task automatic t_nib_read;
    logic [7:0] s; logic o;
    int b = n_dr;
    rdd = 8'h9B;
    strobe(1, 1, 8'hFF, s, o);
    chk("R8 high half", s, 8'h90);
    chk("R8 no pulse yet", n_dr - b, 0);
    strobe(1, 1, 8'hFF, s, o);
    chk("R8 low half", s, 8'hB0);
    chk("R8 one pulse", n_dr - b, 1);
    busy = 1; ac = 7'h2D;
    strobe(0, 1, 8'h00, s, o);
    chk("R8 status high", s, 8'hA0);
    strobe(0, 1, 8'h00, s, o);
    chk("R8 status low", s, 8'hD0);
    busy = 0;
    nib = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_instr_write();
    t_data_write();
    t_status_read();
    t_data_read();
    t_oe_timing();
    t_busy();
    t_nib_write();
    t_nib_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule